// File: doc/BRIEF.md
# Boot Instruction Word Packer

This block sits between a slow boot microcontroller and a processor that is held off while its first instructions are delivered. The microcontroller pushes instruction bytes one at a time; the block gathers them into a full instruction word. On a separate word-ready command it drives that word onto the processor data bus and lets the processor out of its wait state. Once the processor's read of the word has ended, the block puts the processor back into wait and starts gathering the next word.

The byte input is a valid-only stream: `byte_valid` marks one byte for one cycle. There is no ready signal and no back-pressure. The block accepts a byte on every cycle in which it is filling and still has room, so the source may strobe on consecutive cycles alongside its own storage read strobe. Once bootstrap is complete, a sleep input parks the block for good. Its bus drivers stay released, the processor is never held again, and every strobe is ignored until the next reset. All inputs are synchronous to `clk`.

Top module: `bootword_unpacker`

## Requirements
- R1: After reset, `wait_n` is 0 (processor held), `bus_oe` is 0, `bus_data` is 0 and `err` is 0.
- R2: While filling and holding fewer than WORD_BYTES bytes, each cycle with `byte_valid` high stores `byte_data`, with no back-pressure. Consecutive strobes on adjacent cycles are all taken. Packing is little-endian: the first byte lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R3: A `word_go` pulse while filling with all WORD_BYTES bytes held makes `bus_oe` 1, `wait_n` 1 and `bus_data` equal to the packed word from the next cycle.
- R4: While the word is presented, `bus_data`, `bus_oe` and `wait_n` hold unchanged until `rd_done`. `byte_valid` and `word_go` have no effect during that time.
- R5: `rd_done` while presenting makes `wait_n` 0 and `bus_oe` 0 from the next cycle. The byte count is cleared, so the next byte lands in bits 7:0 again.
- R6: `word_go` while filling with fewer than WORD_BYTES bytes held does not release the word: `bus_oe` and `wait_n` stay 0. It sets `err` from the next cycle, and `err` stays 1 until reset. Bytes already held are kept, and filling continues.
- R7: Bytes strobed while filling with WORD_BYTES bytes already held are dropped, and the held word is unchanged.
- R8: `sleep` has priority over every other input. From the next cycle, `bus_oe` is 0, `bus_data` is 0 and `wait_n` is 1, and `byte_valid`, `word_go`, `rd_done` and `sleep` have no effect until reset.
- R9: `rd_done` while filling has no effect.
- R10: `bus_data` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_data | input | BYTE_W | Instruction byte from the boot microcontroller |
| byte_valid | input | 1 | Single-cycle byte strobe, no ready |
| word_go | input | 1 | Command to release the packed word |
| rd_done | input | 1 | Pulse marking the end of the processor's read access |
| sleep | input | 1 | Bootstrap finished: enter dormant state until reset |
| bus_data | output | BYTE_W*WORD_BYTES | Word driven toward the processor data bus |
| bus_oe | output | 1 | Data bus driver enable (0 = released) |
| wait_n | output | 1 | Processor wait, active low |
| err | output | 1 | Sticky flag for a word command given before the word was complete |

## Verification
The bench builds the block with its default values, 8-bit bytes and 4 bytes per word. With these values the lane order is visible as a 32-bit pattern, and the full-word limit is reached after only four strobes. This keeps early commands, overfill, back-to-back strobes and a sleep arriving mid-word within a few dozen cycles. A behavioural model built around a byte queue predicts every output on every clock.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_SHOW  = 2'd1,
    ST_SLEEP = 2'd2
  } unpk_state_e;
endpackage

// File: rtl/unpk_lanes.sv
module unpk_lanes #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              take,
  input  logic              clear,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              full
);
  assign full = (cnt == CNT_W'(WORD_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (take)  cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           lane_q <= '0;
      else if (take && cnt == CNT_W'(i))    lane_q <= byte_data;
    end
    assign word[i*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
  import unpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        word_go,
  input  logic        rd_done,
  input  logic        sleep,
  input  logic        full,
  output unpk_state_e state,
  output logic        take,
  output logic        clear,
  output logic        err
);
  unpk_state_e nxt;
  logic        short_go;

  assign take     = (state == ST_FILL) && byte_valid && !full && !sleep;
  assign clear    = (state == ST_SHOW) && rd_done && !sleep;
  assign short_go = (state == ST_FILL) && word_go && !full && !sleep;

  always_comb begin
    nxt = state;
    if (sleep) nxt = ST_SLEEP;
    else begin
      case (state)
        ST_FILL:  if (word_go && full) nxt = ST_SHOW;
        ST_SHOW:  if (rd_done)         nxt = ST_FILL;
        default:  nxt = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FILL;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      err   <= err | short_go;
    end
  end
endmodule

// File: rtl/unpk_drive.sv
module unpk_drive
  import unpk_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  unpk_state_e       state,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              wait_n
);
  assign bus_oe   = (state == ST_SHOW);
  assign bus_data = bus_oe ? word : '0;
  assign wait_n   = (state != ST_FILL);
endmodule

// File: rtl/bootword_unpacker.sv
module bootword_unpacker
  import unpk_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  input  logic              word_go,
  input  logic              rd_done,
  input  logic              sleep,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              wait_n,
  output logic              err
);
  unpk_state_e       state;
  logic              take, clear, full;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  byte_cnt;

  unpk_ctrl u_ctrl (
    .clk, .rst_n, .byte_valid, .word_go, .rd_done, .sleep, .full,
    .state, .take, .clear, .err
  );

  unpk_lanes #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_lanes (
    .clk, .rst_n, .byte_data, .take, .clear, .word, .cnt(byte_cnt), .full
  );

  unpk_drive #(.WORD_W(WORD_W)) u_drive (
    .state, .word, .bus_data, .bus_oe, .wait_n
  );
endmodule

// File: rtl/unpk_checker.sv
module unpk_checker
  import unpk_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(WORD_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_go,
  input logic              rd_done,
  input logic              sleep,
  input logic [WORD_W-1:0] bus_data,
  input logic              bus_oe,
  input logic              wait_n,
  input logic              err,
  input logic [CNT_W-1:0]  cnt,
  input unpk_state_e       state
);
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && word_go && !sleep && cnt == CNT_W'(WORD_BYTES)) |=> (bus_oe && wait_n));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !rd_done && !sleep) |=> (bus_oe && $stable(bus_data)));

  assert_rewait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && rd_done && !sleep) |=> (!wait_n && !bus_oe && cnt == '0));

  assert_short_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && word_go && !sleep && cnt < CNT_W'(WORD_BYTES)) |=> (err && !bus_oe && !wait_n));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_sleep_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!bus_oe && wait_n));

  assert_sleep_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state == ST_SLEEP));

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));
endmodule

bind bootword_unpacker unpk_checker #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_go(word_go), .rd_done(rd_done), .sleep(sleep),
  .bus_data(bus_data), .bus_oe(bus_oe), .wait_n(wait_n), .err(err),
  .cnt(byte_cnt), .state(state)
);

// File: tb/sim_bootword_unpacker.sv
module sim_bootword_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int WDOG = 5000;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  byte_data = 0;
  logic        byte_valid = 0, word_go = 0, rd_done = 0, sleep = 0;
  logic [31:0] bus_data;
  logic        bus_oe, wait_n, err;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootword_unpacker u0 (.*);

  // behavioural model: 0 filling, 1 presenting, 2 dormant
  int         m_phase = 0;
  logic [7:0] m_q[$];
  logic [31:0] m_word = 0;
  bit         m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_q.delete(); m_err = 0; m_word = 0;
    end else if (sleep) begin
      m_phase = 2;
    end else if (m_phase == 0) begin
      if (word_go && m_q.size() == NB) begin
        m_word = 0;
        foreach (m_q[k]) m_word = m_word | (32'(m_q[k]) << (8*k));
        m_phase = 1;
      end else begin
        if (word_go) m_err = 1;
        if (byte_valid && m_q.size() < NB) m_q.push_back(byte_data);
      end
    end else if (m_phase == 1) begin
      if (rd_done) begin m_q.delete(); m_phase = 0; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 bus_data vs model", bus_data, (m_phase == 1) ? m_word : 32'h0);
    chk("R5 bus_oe vs model", 32'(bus_oe), 32'(m_phase == 1));
    chk("R4 wait_n vs model", 32'(wait_n), 32'(m_phase != 0));
    chk("R6 err vs model", 32'(err), 32'(m_err));
  end

  task automatic drive(bit bv, logic [7:0] b, bit wg, bit rd, bit sl);
    @(negedge clk);
    byte_valid = bv; byte_data = b; word_go = wg; rd_done = rd; sleep = sl;
  endtask
  task automatic idle(); drive(0, 8'h00, 0, 0, 0); endtask
  task automatic push(logic [7:0] b); drive(1, b, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset wait_n", 32'(wait_n), 0);
    chk("R1 reset bus_oe", 32'(bus_oe), 0);
    chk("R1 reset bus_data", bus_data, 0);
    chk("R1 reset err", 32'(err), 0);

    // R2/R3: back-to-back bytes, then release
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    idle(); idle();
    drive(0, 0, 1, 0, 0);
    idle();
    chk("R3 released bus_oe", 32'(bus_oe), 1);
    chk("R2 little-endian word", bus_data, 32'h44332211);
    // R4: strobes ignored while presenting
    drive(1, 8'hEE, 1, 0, 0);
    idle(); idle();
    chk("R4 word held", bus_data, 32'h44332211);
    // R5: read end
    drive(0, 0, 0, 1, 0);
    idle();
    chk("R5 wait reasserted", 32'(wait_n), 0);
    chk("R5 bus released", 32'(bus_oe), 0);
    // R9: rd_done while filling
    drive(0, 0, 0, 1, 0); idle();
    chk("R9 rd_done ignored", 32'(wait_n), 0);

    // R6: early word_go
    push(8'hA1); push(8'hB2);
    drive(0, 0, 1, 0, 0); idle();
    chk("R6 err set", 32'(err), 1);
    chk("R6 no release", 32'(bus_oe), 0);
    push(8'hC3); push(8'hD4);
    drive(0, 0, 1, 0, 0); idle();
    chk("R6 bytes kept", bus_data, 32'hD4C3B2A1);
    drive(0, 0, 0, 1, 0); idle();

    // R7: overfill, then release; also R5 count cleared
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05); push(8'h06);
    drive(0, 0, 1, 0, 0); idle();
    chk("R7 extra bytes dropped", bus_data, 32'h04030201);
    chk("R6 err sticky", 32'(err), 1);
    drive(0, 0, 0, 1, 0); idle();

    // R8: sleep mid-word, strobes ignored afterwards
    push(8'h77); push(8'h88);
    drive(0, 0, 0, 0, 1); idle();
    chk("R8 dormant wait_n", 32'(wait_n), 1);
    chk("R8 dormant bus_oe", 32'(bus_oe), 0);
    push(8'h99); push(8'hAA);
    drive(0, 0, 1, 0, 0); idle();
    drive(0, 0, 0, 1, 0); idle();
    chk("R8 strobes ignored oe", 32'(bus_oe), 0);
    chk("R10 bus quiet", bus_data, 0);
    chk("R8 still not waiting", 32'(wait_n), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule